// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and signals one interrupt towards a processor. It decides which line to serve, and on acknowledge it hands back an 8-bit vector. Software reaches it through a two-address byte port. Address 0 is the command port. Address 1 is the data port, which takes configuration words and the mask.

Software first writes a start word to the command port. It then writes three data words: the vector base, a cascade word that is stored and has no other effect, and an options word that can turn on automatic end of interrupt. From then on, data-port writes load the mask. Command-port writes either end service of one level or select which register the command port reads back. Priority is fixed, with line 0 highest. A request that vanishes before acknowledge is answered with the lowest level's vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_out` and `vec_valid` are low, the data port reads 0xFF (all masked), and the command port reads 0x00.
- R2: A command write with data bit 4 set starts configuration and clears the request register, the in-service register and the mask, and selects request readback. The next three data writes are taken as the vector base, the cascade word (stored only), and the options word, in that order.
- R3: Once configuration is done, a data write loads the mask. Bit n set masks line n. A data-port read returns the mask.
- R4: A rising edge on `irq_in[n]` sets request bit n. The bit clears when that level is acknowledged, or when the line falls before acknowledge.
- R5: `int_out` is high only after configuration, and only while some unmasked pending request has a lower index (higher priority) than every in-service level. Line 0 has the highest priority.
- R6: An `ack` pulse in a cycle where `int_out` is high moves the winning level from the request register to the in-service register. In the next cycle `vec_valid` is high for one cycle and `vec_out` equals base plus the level index.
- R7: A command write of 0x60 plus k (k = 0..7) clears in-service bit k only.
- R8: A command write of 0x0B makes command-port reads return the in-service register. A command write of 0x0A makes them return the request register.
- R9: When bit 1 of the options word is set, acknowledge clears the request bit but leaves the in-service register unchanged.
- R10: An `ack` in a cycle where `int_out` is low returns base plus 7 and changes no in-service bit. This holds even when level 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_a0 | input | 1 | Port select: 0 command, 1 data |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, gates `bus_rdata` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector strobe, one cycle after `ack` |
| vec_out | output | 8 | Interrupt vector |

## Verification
The bench builds the block with its default parameter, eight levels. With eight levels the spurious answer lands on level 7, and every command code in the requirements is in range. Two vector bases, 0x40 and 0x80, are used across a full reconfiguration. This lets the bench check that vectors follow the base and that the automatic end-of-interrupt option is turned on and off by configuration alone. Masking level 7 during the withdrawn-request case shows that the spurious answer ignores the mask.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      CFG_IDLE = 2'd0,
      CFG_BASE = 2'd1,
      CFG_CASC = 2'd2,
      CFG_OPTS = 2'd3
   } cfg_phase_e;

   // upper five bits of a specific end-of-interrupt command
   localparam logic [4:0] EOI_OPCODE = 5'b01100;
   // position of the option bit that enables automatic end of interrupt
   localparam int AUTO_EOI_BIT = 1;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
   import pic_pkg::*;
#(
   parameter int NUM_LVL = 8,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_a0,
   input  logic               bus_wr,
   input  logic [BYTE_W-1:0]  bus_wdata,
   output logic [NUM_LVL-1:0] mask_q,
   output logic [BYTE_W-1:0]  base_q,
   output logic [BYTE_W-1:0]  cascade_q,
   output logic               aeoi_q,
   output logic               ready_q,
   output logic               sel_isr_q,
   output logic               init_clr,
   output logic               eoi_fire,
   output logic [LVL_W-1:0]   eoi_lvl
);
   cfg_phase_e phase_q;
   logic cmd_wr, dat_wr;

   assign cmd_wr   = bus_wr && !bus_a0;
   assign dat_wr   = bus_wr && bus_a0;
   assign init_clr = cmd_wr && bus_wdata[4];
   assign eoi_fire = cmd_wr && ready_q && (bus_wdata[7:3] == EOI_OPCODE)
                     && ({5'b0, bus_wdata[2:0]} < BYTE_W'(NUM_LVL));
   assign eoi_lvl  = bus_wdata[LVL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= CFG_IDLE;
         ready_q   <= 1'b0;
         mask_q    <= '1;
         base_q    <= '0;
         cascade_q <= '0;
         aeoi_q    <= 1'b0;
         sel_isr_q <= 1'b0;
      end else if (init_clr) begin
         phase_q   <= CFG_BASE;
         ready_q   <= 1'b0;
         mask_q    <= '0;
         aeoi_q    <= 1'b0;
         sel_isr_q <= 1'b0;
      end else if (cmd_wr) begin
         if (ready_q && bus_wdata[3] && bus_wdata[1])
            sel_isr_q <= bus_wdata[0];
      end else if (dat_wr) begin
         unique case (phase_q)
            CFG_BASE: begin
               base_q  <= bus_wdata;
               phase_q <= CFG_CASC;
            end
            CFG_CASC: begin
               cascade_q <= bus_wdata;
               phase_q   <= CFG_OPTS;
            end
            CFG_OPTS: begin
               aeoi_q  <= bus_wdata[AUTO_EOI_BIT];
               ready_q <= 1'b1;
               phase_q <= CFG_IDLE;
            end
            default: begin
               if (ready_q)
                  mask_q <= bus_wdata[NUM_LVL-1:0];
            end
         endcase
      end
   end
endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
   parameter int NUM_LVL = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] irq_in,
   input  logic               init_clr,
   input  logic [NUM_LVL-1:0] ack_clr,
   output logic [NUM_LVL-1:0] irr_q
);
   logic [NUM_LVL-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= irq_in;
   end

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      logic rise;
      assign rise = irq_in[g] && !prev_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       irr_q[g] <= 1'b0;
         else if (init_clr)                irr_q[g] <= 1'b0;
         else if (rise)                    irr_q[g] <= 1'b1;
         else if (!irq_in[g] || ack_clr[g]) irr_q[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
   parameter int NUM_LVL = 8,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input  logic [NUM_LVL-1:0] irr,
   input  logic [NUM_LVL-1:0] mask,
   input  logic [NUM_LVL-1:0] isr,
   input  logic               ready,
   output logic               grant_ok,
   output logic [LVL_W-1:0]   grant_idx
);
   logic [NUM_LVL-1:0] live;
   logic               any_live;
   logic [LVL_W-1:0]   win;
   logic [LVL_W:0]     top_isr;

   assign live = irr & ~mask;

   always_comb begin
      any_live = 1'b0;
      win      = '0;
      top_isr  = (LVL_W+1)'(NUM_LVL);
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
         if (live[i]) begin
            any_live = 1'b1;
            win      = LVL_W'(i);
         end
         if (isr[i])
            top_isr = (LVL_W+1)'(i);
      end
   end

   assign grant_ok  = ready && any_live && ({1'b0, win} < top_isr);
   assign grant_idx = win;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int NUM_LVL = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_a0,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [BYTE_W-1:0]  bus_wdata,
   output logic [BYTE_W-1:0]  bus_rdata,
   input  logic [NUM_LVL-1:0] irq_in,
   output logic               int_out,
   input  logic               ack,
   output logic               vec_valid,
   output logic [BYTE_W-1:0]  vec_out
);
   localparam int LVL_W = $clog2(NUM_LVL);
   localparam logic [BYTE_W-1:0] SPUR_IDX = BYTE_W'(NUM_LVL - 1);

   if (NUM_LVL < 2 || NUM_LVL > BYTE_W || (1 << LVL_W) != NUM_LVL) begin : g_bad_cfg
      $error("NUM_LVL must be a power of two between 2 and 8");
   end

   logic [NUM_LVL-1:0] mask_q, irr_q, isr_q, ack_clr, isr_set, isr_clr;
   logic [BYTE_W-1:0]  base_q, cascade_q;
   logic               aeoi_q, ready_q, sel_isr_q, init_clr, eoi_fire;
   logic [LVL_W-1:0]   eoi_lvl, grant_idx;
   logic               grant_ok, take;

   pic_cfg_regs #(.NUM_LVL(NUM_LVL)) cfg_i (
      .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .mask_q(mask_q), .base_q(base_q),
      .cascade_q(cascade_q), .aeoi_q(aeoi_q), .ready_q(ready_q),
      .sel_isr_q(sel_isr_q), .init_clr(init_clr), .eoi_fire(eoi_fire),
      .eoi_lvl(eoi_lvl)
   );

   pic_req_capture #(.NUM_LVL(NUM_LVL)) req_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .init_clr(init_clr),
      .ack_clr(ack_clr), .irr_q(irr_q)
   );

   pic_prio_resolve #(.NUM_LVL(NUM_LVL)) res_i (
      .irr(irr_q), .mask(mask_q), .isr(isr_q), .ready(ready_q),
      .grant_ok(grant_ok), .grant_idx(grant_idx)
   );

   assign int_out = grant_ok;
   assign take    = ack && grant_ok;
   assign ack_clr = take ? (NUM_LVL'(1) << grant_idx) : '0;
   assign isr_set = aeoi_q ? '0 : ack_clr;
   assign isr_clr = eoi_fire ? (NUM_LVL'(1) << eoi_lvl) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        isr_q <= '0;
      else if (init_clr) isr_q <= '0;
      else               isr_q <= (isr_q & ~isr_clr) | isr_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         vec_valid <= ack;
         if (ack)
            vec_out <= base_q + (take ? BYTE_W'(grant_idx) : SPUR_IDX);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_a0)         bus_rdata = BYTE_W'(mask_q);
         else if (sel_isr_q) bus_rdata = BYTE_W'(isr_q);
         else                bus_rdata = BYTE_W'(irr_q);
      end
   end
endmodule

// File: rtl/pic_irq_checker.sv
module pic_irq_checker #(
   parameter int NUM_LVL = 8,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_a0,
   input logic               bus_wr,
   input logic [7:0]         bus_wdata,
   input logic               ack,
   input logic               int_out,
   input logic               vec_valid,
   input logic [7:0]         vec_out,
   input logic [NUM_LVL-1:0] isr_q,
   input logic [NUM_LVL-1:0] mask_q,
   input logic [7:0]         base_q,
   input logic [7:0]         cascade_q,
   input logic               aeoi_q,
   input logic               ready_q
);
   assert_int_needs_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ready_q);

   assert_vec_follows_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> vec_valid);

   assert_no_stray_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !vec_valid);

   assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_a0 && ready_q) |=> (mask_q == $past(bus_wdata[NUM_LVL-1:0])));

   assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_a0 && ready_q && bus_wdata[7:3] == 5'b01100
       && {5'b0, bus_wdata[2:0]} < 8'(NUM_LVL))
      |=> !isr_q[$past(bus_wdata[LVL_W-1:0])]);

   assert_auto_eoi_keeps_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && aeoi_q && !bus_wr) |=> (isr_q == $past(isr_q)));

   assert_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !int_out && !bus_wr)
      |=> (vec_out == 8'($past(base_q) + 8'(NUM_LVL - 1))) && (isr_q == $past(isr_q)));

   assert_cascade_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(cascade_q));
endmodule

bind prio_irq_ctrl pic_irq_checker #(.NUM_LVL(NUM_LVL)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .ack(ack), .int_out(int_out),
   .vec_valid(vec_valid), .vec_out(vec_out), .isr_q(isr_q),
   .mask_q(mask_q), .base_q(base_q), .cascade_q(cascade_q),
   .aeoi_q(aeoi_q), .ready_q(ready_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] irq_in = '0;
   logic       int_out, ack = 1'b0, vec_valid;
   logic [7:0] vec_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .int_out(int_out), .ack(ack),
      .vec_valid(vec_valid), .vec_out(vec_out)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a0, input logic [7:0] d);
      @(negedge clk);
      bus_a0 = a0; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a0, output logic [7:0] d);
      @(negedge clk);
      bus_a0 = a0; bus_rd = 1'b1;
      #2 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic set_irq(input int idx, input logic v);
      @(negedge clk);
      irq_in[idx] = v;
      @(negedge clk);
   endtask

   task automatic do_ack(input string tag, input logic [7:0] exp_vec);
      @(negedge clk);
      exp_q.push_back(exp_vec);
      tag_q.push_back(tag);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   // monitor: pop the expected vector for each strobe
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R6: actual vector %02h expected none", vec_out);
         end else begin
            chk(tag_q.pop_front(), vec_out, exp_q.pop_front());
         end
      end
   end

   initial begin
      #4_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 int", {7'b0, int_out}, 8'h00);
      chk("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
      rd(1'b1, d); chk("R1 mask", d, 8'hFF);
      rd(1'b0, d); chk("R1 cmd read", d, 8'h00);

      // R2 configuration: base 0x40, cascade 0x04, normal EOI
      wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
      rd(1'b1, d); chk("R2 mask cleared", d, 8'h00);

      // R3 mask load
      wr(1'b1, 8'hF0);
      rd(1'b1, d); chk("R3 mask readback", d, 8'hF0);

      // R4 / R5 request capture and priority
      set_irq(3, 1'b1);
      rd(1'b0, d); chk("R4 irr lvl3", d, 8'h08);
      chk("R5 int on lvl3", {7'b0, int_out}, 8'h01);
      set_irq(5, 1'b1);
      set_irq(1, 1'b1);
      rd(1'b0, d); chk("R4 irr three", d, 8'h2A);

      // R6 ack picks level 1
      do_ack("R6 vec lvl1", 8'h41);
      rd(1'b0, d); chk("R6 irr after ack", d, 8'h28);
      chk("R5 blocked by isr", {7'b0, int_out}, 8'h00);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R8 isr read", d, 8'h02);

      // R7 specific EOI
      wr(1'b0, 8'h61);
      rd(1'b0, d); chk("R7 isr cleared", d, 8'h00);
      chk("R5 int after eoi", {7'b0, int_out}, 8'h01);
      do_ack("R6 vec lvl3", 8'h43);
      rd(1'b0, d); chk("R6 isr lvl3", d, 8'h08);
      wr(1'b0, 8'h60);
      rd(1'b0, d); chk("R7 other level kept", d, 8'h08);
      wr(1'b0, 8'h63);
      rd(1'b0, d); chk("R7 lvl3 cleared", d, 8'h00);

      // R8 back to request readback
      wr(1'b0, 8'h0A);
      rd(1'b0, d); chk("R8 irr read", d, 8'h20);

      // R4 withdrawal, R10 spurious with level 7 masked
      set_irq(2, 1'b1);
      chk("R5 int lvl2", {7'b0, int_out}, 8'h01);
      set_irq(2, 1'b0);
      rd(1'b0, d); chk("R4 withdrawn", d, 8'h20);
      chk("R4 int dropped", {7'b0, int_out}, 8'h00);
      do_ack("R10 spurious vec", 8'h47);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R10 isr untouched", d, 8'h00);

      // R2 reconfiguration with auto EOI, base 0x80
      wr(1'b0, 8'h11);
      chk("R5 int during cfg", {7'b0, int_out}, 8'h00);
      wr(1'b1, 8'h80); wr(1'b1, 8'h04); wr(1'b1, 8'h02);
      rd(1'b1, d); chk("R2 mask after recfg", d, 8'h00);
      set_irq(6, 1'b1);
      rd(1'b0, d); chk("R2 readback reset to irr", d, 8'h40);
      do_ack("R9 vec lvl6", 8'h86);
      rd(1'b0, d); chk("R9 irr cleared", d, 8'h00);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R9 isr empty", d, 8'h00);
      chk("R9 int idle", {7'b0, int_out}, 8'h00);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R6: actual %0d vectors missing expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule